// File: doc/BRIEF.md
# Ultra DMA Device Burst Controller

This block is the device-side engine for Ultra DMA data bursts on a parallel ATA-style storage link. Once the command layer asks for a burst, the block raises the DMA request. It waits for the host to acknowledge with STOP negated, and then moves 16-bit words. Every change of the strobe, rising or falling, carries one word. In a read burst the device sources words from a word FIFO and drives its own strobe. In a write burst the host toggles its strobe, and the device captures each word into a sink FIFO.

Either side can pause a burst. The host pauses by withholding its ready signal. The device pauses when its FIFO cannot keep up. Either side can also end a burst. In a host-initiated end, the host raises STOP and the device drops its request. In a device-initiated end, the device drops its request first and then waits for STOP. A 16-bit CRC is accumulated over every word moved. The CRC word is presented before the host releases its acknowledge and is held for a few cycles afterwards.

The active Ultra DMA mode (0 to 5) is set through a mode write port. It selects how many core clocks must separate two device strobe edges. After reset no Ultra DMA mode is selected, and burst requests are refused until a mode is written.

Top module: `udma_burst_ctrl`

## Requirements
- R1: After reset `dmarq` is 0, `crc_valid` is 0, `dd_oe` is 0, `drdy_n` is 1, and no Ultra DMA mode is selected. While no mode is selected, `burst_go` does not start a burst.
- R2: `dmarq_oe` is 1 only while `dev_sel` is 1. A `burst_go` pulse seen while `dev_sel` is 0 starts no burst.
- R3: A `mode_wr` pulse with `mode_val` from 0 to 5 selects that mode and enables bursts. The values 6 and 7 are ignored.
- R4: While idle, activity on `dmack_n` and `stop` has no effect: `dmarq`, `dd_oe` and `crc_valid` stay 0.
- R5: In a read burst (`burst_rd`=1), each change of `dstrobe` in either direction delivers the next source word on `dd_out`, in FIFO order.
- R6: The device strobe edges are at least N core clocks apart. With `CLK_PS`=4000, N is 29, 20, 15, 11, 8 and 5 for modes 0 to 5, taken from minimum two-edge times of 230, 153, 115, 86, 57 and 38 ns. When nothing stalls, the spacing is exactly N.
- R7: While `hrdy_n` is 1 during a read burst, `dstrobe` does not change.
- R8: A device pause happens when the source is empty in a read burst, and then `dstrobe` does not change. In a write burst, `drdy_n` is 1 while `snk_full` is 1, and no word is pushed in that time.
- R9: In a write burst, each change of `hstrobe` while `drdy_n` is 0 pushes `dd_in` to the sink, in order.
- R10: If `stop` is raised during transfer, `dmarq` is 0 on the next cycle and the CRC word becomes valid.
- R11: When `dev_end` is raised during transfer, `dmarq` falls once no read word is pending. `crc_valid` stays 0 until the host raises `stop`.
- R12: The CRC uses the polynomial x^16+x^12+x^5+1. Each word is fed MSB first, and the seed is 4ABAh at every burst start. `crc_word` is valid from the end handshake until `HOLD_CYC` cycles after `dmack_n` rises.
- R13: An accepted `burst_go` raises `dmarq` one cycle later. The transfer begins when `dmack_n` is 0 and `stop` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dev_sel | input | 1 | This device is selected by the drive bit |
| mode_wr | input | 1 | Mode write strobe |
| mode_val | input | 3 | Ultra DMA mode number |
| burst_go | input | 1 | Start a burst (one-cycle pulse) |
| burst_rd | input | 1 | Burst direction: 1 means device to host |
| dev_end | input | 1 | Back end asks to end the burst |
| dmarq | output | 1 | DMA request |
| dmarq_oe | output | 1 | Output enable for the DMA request |
| dmack_n | input | 1 | Host DMA acknowledge, active low |
| stop | input | 1 | Host STOP |
| hrdy_n | input | 1 | Host ready for read data, active low |
| hstrobe | input | 1 | Host data strobe for write bursts |
| drdy_n | output | 1 | Device ready for write data, active low |
| dstrobe | output | 1 | Device data strobe for read bursts |
| dd_out | output | 16 | Read data toward the host |
| dd_oe | output | 1 | Drive enable for `dd_out` |
| dd_in | input | 16 | Write data from the host |
| src_data | input | 16 | Head word of the source FIFO |
| src_empty | input | 1 | Source FIFO empty |
| src_pop | output | 1 | Take the head word of the source FIFO |
| snk_data | output | 16 | Word pushed to the sink FIFO |
| snk_full | input | 1 | Sink FIFO full |
| snk_push | output | 1 | Push `snk_data` into the sink FIFO |
| crc_word | output | 16 | Burst CRC |
| crc_valid | output | 1 | `crc_word` is valid |

## Verification
The slowest mode and the fastest mode are run as read bursts, and mode 3 is run as a write burst. The read bursts use runs where nothing stalls, which show whether the edge spacing equals the mode count exactly rather than merely exceeding it. Source starvation and host withholding are applied one at a time, so a design that confuses the two pause causes shows up as a strobe change inside the wrong window. A host-ended read and a device-ended read expose the different orders of the request drop, STOP and CRC validity. A write burst with a full sink in the middle separates pushes gated by readiness from pushes taken on every host edge.

// File: rtl/udma_pkg.sv
// Shared types and helpers for the Ultra DMA burst controller.
// Assumes the mode number is 0..5; any larger value is treated as mode 5.
package udma_pkg;

    localparam int          WORD_W   = 16;
    localparam logic [2:0]  MODE_MAX = 3'd5;
    localparam logic [15:0] CRC_SEED = 16'h4ABA;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_XFER,
        ST_DTERM,
        ST_FIN,
        ST_HOLD
    } burst_st_e;

    // Minimum two-edge strobe time in ns for a mode.
    function automatic int unsigned t2cyc_ns(input logic [2:0] m);
        case (m)
            3'd0:    return 230;
            3'd1:    return 153;
            3'd2:    return 115;
            3'd3:    return 86;
            3'd4:    return 57;
            default: return 38;
        endcase
    endfunction

    // Core clocks needed between two strobe edges (half the two-edge time, rounded up).
    function automatic int unsigned edge_clks(input logic [2:0] m, input int unsigned clk_ps);
        return (t2cyc_ns(m) * 1000 + 2 * clk_ps - 1) / (2 * clk_ps);
    endfunction

    // One 16-bit word into the CRC, MSB first, polynomial 1021h.
    function automatic logic [15:0] crc16_step(input logic [15:0] crc, input logic [15:0] d);
        logic [15:0] c;
        c = crc;
        for (int i = 15; i >= 0; i--) begin
            if (c[15] ^ d[i]) c = {c[14:0], 1'b0} ^ 16'h1021;
            else              c = {c[14:0], 1'b0};
        end
        return c;
    endfunction

endpackage

// File: rtl/udma_mode_reg.sv
// Holds the selected Ultra DMA mode and whether any mode is selected.
// Assumes mode writes arrive as single-cycle pulses; values above MODE_MAX are dropped.
module udma_mode_reg
    import udma_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_wr,
    input  logic [2:0] mode_val,
    output logic [2:0] mode_q,
    output logic       udma_on
);

    // Capture a legal mode; reset returns to no Ultra DMA mode selected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= 3'd0;
            udma_on <= 1'b0;
        end else if (mode_wr && (mode_val <= MODE_MAX)) begin
            mode_q  <= mode_val;
            udma_on <= 1'b1;
        end
    end

endmodule

// File: rtl/udma_strobe_timer.sv
// Counts core clocks since the last device strobe edge and reports when the next may fire.
// Assumes arm is pulsed on entry to transfer and restart on every strobe edge.
module udma_strobe_timer
    import udma_pkg::*;
#(
    parameter int unsigned CLK_PS = 4000,
    parameter int          CW     = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode,
    input  logic       arm,
    input  logic       restart,
    output logic       ok
);

    logic [CW-1:0] lim;
    logic [CW-1:0] cnt;

    // Edge spacing limit for the active mode.
    always_comb lim = CW'(edge_clks(mode, CLK_PS));

    // Saturating spacing counter.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (restart)        cnt <= CW'(1);
        else if (arm)            cnt <= lim;
        else if (cnt < lim)      cnt <= cnt + CW'(1);
    end

    assign ok = (cnt >= lim);

endmodule

// File: rtl/udma_crc16.sv
// Burst CRC accumulator: seeded at burst start, advanced once per moved word.
// Assumes seed and update are never requested in the same cycle.
module udma_crc16
    import udma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seed,
    input  logic              upd,
    input  logic [WORD_W-1:0] din,
    output logic [15:0]       crc
);

    // Seed or advance the CRC register.
    always_ff @(posedge clk) begin
        if (!rst_n)    crc <= CRC_SEED;
        else if (seed) crc <= CRC_SEED;
        else if (upd)  crc <= crc16_step(crc, din);
    end

endmodule

// File: rtl/udma_burst_ctrl.sv
// Device-side Ultra DMA burst controller: request/acknowledge, double-edge word
// transfer in both directions, pauses, termination from either side, CRC presentation.
// Assumes host-side inputs are already synchronous to clk.
module udma_burst_ctrl
    import udma_pkg::*;
#(
    parameter int unsigned CLK_PS   = 4000,
    parameter int unsigned HOLD_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dev_sel,
    input  logic              mode_wr,
    input  logic [2:0]        mode_val,
    input  logic              burst_go,
    input  logic              burst_rd,
    input  logic              dev_end,
    output logic              dmarq,
    output logic              dmarq_oe,
    input  logic              dmack_n,
    input  logic              stop,
    input  logic              hrdy_n,
    input  logic              hstrobe,
    output logic              drdy_n,
    output logic              dstrobe,
    output logic [WORD_W-1:0] dd_out,
    output logic              dd_oe,
    input  logic [WORD_W-1:0] dd_in,
    input  logic [WORD_W-1:0] src_data,
    input  logic              src_empty,
    output logic              src_pop,
    output logic [WORD_W-1:0] snk_data,
    input  logic              snk_full,
    output logic              snk_push,
    output logic [15:0]       crc_word,
    output logic              crc_valid
);

    localparam int unsigned EDGE_MAX = edge_clks(3'd0, CLK_PS);
    localparam int          CW       = $clog2(EDGE_MAX + 1) + 1;
    localparam int          HW       = $clog2(HOLD_CYC + 1) + 1;

    burst_st_e         st, st_nx;
    logic              rd_q;
    logic              have_word;
    logic [WORD_W-1:0] data_q;
    logic [HW-1:0]     hold_cnt;
    logic              hstrobe_q;
    logic              dstrobe_q;
    logic [2:0]        mode_q;
    logic              udma_on;
    logic              tmr_ok;
    logic              start, load, fire, cap, wr_ready, arm;

    udma_mode_reg u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_wr (mode_wr),
        .mode_val(mode_val),
        .mode_q  (mode_q),
        .udma_on (udma_on)
    );

    udma_strobe_timer #(.CLK_PS(CLK_PS), .CW(CW)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (mode_q),
        .arm    (arm),
        .restart(fire),
        .ok     (tmr_ok)
    );

    udma_crc16 u_crc (
        .clk  (clk),
        .rst_n(rst_n),
        .seed (start),
        .upd  (fire | cap),
        .din  (fire ? data_q : dd_in),
        .crc  (crc_word)
    );

    // Datapath enables for both burst directions.
    always_comb begin
        start    = (st == ST_IDLE) && burst_go && dev_sel && udma_on;
        load     = (st == ST_XFER) && rd_q && !have_word && !src_empty && !stop && !dev_end;
        fire     = (st == ST_XFER) && rd_q && have_word && !hrdy_n && !stop && tmr_ok;
        wr_ready = (st == ST_XFER) && !rd_q && !snk_full && !stop;
        cap      = wr_ready && (hstrobe != hstrobe_q);
        arm      = (st == ST_REQ) && (st_nx == ST_XFER);
    end

    // Burst sequencing from request through CRC hold.
    always_comb begin
        st_nx = st;
        case (st)
            ST_IDLE:  if (start) st_nx = ST_REQ;
            ST_REQ:   if (!dmack_n && !stop) st_nx = ST_XFER;
            ST_XFER: begin
                if (stop)
                    st_nx = ST_FIN;
                else if (dev_end && !fire && (!rd_q || !have_word))
                    st_nx = ST_DTERM;
            end
            ST_DTERM: if (stop) st_nx = ST_FIN;
            ST_FIN:   if (dmack_n) st_nx = ST_HOLD;
            ST_HOLD:  if (hold_cnt == HW'(HOLD_CYC - 1)) st_nx = ST_IDLE;
            default:  st_nx = ST_IDLE;
        endcase
    end

    // State, direction and hold counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            rd_q     <= 1'b0;
            hold_cnt <= '0;
        end else begin
            st       <= st_nx;
            if (start) rd_q <= burst_rd;
            hold_cnt <= (st == ST_HOLD) ? hold_cnt + HW'(1) : '0;
        end
    end

    // Read-side word staging and device strobe toggling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_word <= 1'b0;
            data_q    <= '0;
            dstrobe_q <= 1'b1;
        end else begin
            if (start)     have_word <= 1'b0;
            else if (load) have_word <= 1'b1;
            else if (fire) have_word <= 1'b0;
            if (load) data_q <= src_data;
            if (fire) dstrobe_q <= ~dstrobe_q;
        end
    end

    // Host strobe history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) hstrobe_q <= 1'b0;
        else        hstrobe_q <= hstrobe;
    end

    assign dmarq     = (st == ST_REQ) || (st == ST_XFER);
    assign dmarq_oe  = dev_sel;
    assign dd_oe     = rd_q && (st == ST_XFER);
    assign dd_out    = data_q;
    assign dstrobe   = dstrobe_q;
    assign drdy_n    = !(wr_ready && !dev_end);
    assign src_pop   = load;
    assign snk_push  = cap;
    assign snk_data  = dd_in;
    assign crc_valid = (st == ST_FIN) || (st == ST_HOLD);

endmodule

// File: rtl/udma_burst_chk.sv
// Protocol checker for udma_burst_ctrl, attached by bind.
// Assumes it sees the controller's state and ports directly.
module udma_burst_chk
    import udma_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input burst_st_e   st,
    input logic        burst_go,
    input logic        dstrobe,
    input logic        src_pop,
    input logic        src_empty,
    input logic        snk_push,
    input logic        snk_full,
    input logic        stop,
    input logic        dmarq,
    input logic        dmack_n,
    input logic        crc_valid,
    input logic [15:0] crc_word
);

    logic [5:0] gap;
    logic       ds_q;

    // Cycles since the last observed device strobe change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap  <= 6'h3F;
            ds_q <= dstrobe;
        end else begin
            ds_q <= dstrobe;
            if (dstrobe != ds_q)  gap <= 6'd1;
            else if (gap != 6'h3F) gap <= gap + 6'd1;
        end
    end

    AST_IDLE_ACK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && !burst_go) |=> (st == ST_IDLE)); // R4
    AST_STROBE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (dstrobe != ds_q) |-> (gap >= 6'd5)); // R6
    AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        src_pop |-> !src_empty); // R8
    AST_PUSH_NOTFULL: assert property (@(posedge clk) disable iff (!rst_n)
        snk_push |-> !snk_full); // R8
    AST_HOST_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_XFER && stop) |=> !dmarq); // R10
    AST_DEV_END_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DTERM && !stop) |=> !crc_valid); // R11
    AST_CRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FIN && dmack_n) |=> (crc_valid && $stable(crc_word))); // R12

endmodule

bind udma_burst_ctrl udma_burst_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .st       (st),
    .burst_go (burst_go),
    .dstrobe  (dstrobe),
    .src_pop  (src_pop),
    .src_empty(src_empty),
    .snk_push (snk_push),
    .snk_full (snk_full),
    .stop     (stop),
    .dmarq    (dmarq),
    .dmack_n  (dmack_n),
    .crc_valid(crc_valid),
    .crc_word (crc_word)
);

// File: tb/udma_burst_ctrl_bench.sv
`timescale 1ns/1ps
// Host model and scoreboard for udma_burst_ctrl. Expected word streams are
// generated from an index; monitors compare each transferred word as it appears.
module udma_burst_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dev_sel = 1'b1, mode_wr = 1'b0, burst_go = 1'b0, burst_rd = 1'b0, dev_end = 1'b0;
    logic [2:0]  mode_val = 3'd0;
    logic        dmack_n = 1'b1, stop = 1'b0, hrdy_n = 1'b1, hstrobe = 1'b0, snk_full = 1'b0;
    logic [15:0] dd_in = 16'h0;
    logic        dmarq, dmarq_oe, drdy_n, dstrobe, dd_oe, src_pop, snk_push, crc_valid;
    logic [15:0] dd_out, snk_data, crc_word, src_data;
    logic        src_empty;

    int tot = 0, bad = 0;          // main-process checks
    int rtot = 0, rbad = 0;        // read monitor checks
    int wtot = 0, wbad = 0;        // write monitor checks
    int src_avail = 0;             // words offered by the driver
    int src_rd = 0;                // words taken by the design
    int rx_idx = 0, edges = 0, exact = 0, short_gaps = 0, gap = 63;
    int snk_idx = 0;
    int lim_exp = 29;
    logic ds_prev = 1'b1;

    always #2 clk = ~clk;

    udma_burst_ctrl u_udma_burst_ctrl (
        .clk(clk), .rst_n(rst_n), .dev_sel(dev_sel), .mode_wr(mode_wr), .mode_val(mode_val),
        .burst_go(burst_go), .burst_rd(burst_rd), .dev_end(dev_end), .dmarq(dmarq),
        .dmarq_oe(dmarq_oe), .dmack_n(dmack_n), .stop(stop), .hrdy_n(hrdy_n), .hstrobe(hstrobe),
        .drdy_n(drdy_n), .dstrobe(dstrobe), .dd_out(dd_out), .dd_oe(dd_oe), .dd_in(dd_in),
        .src_data(src_data), .src_empty(src_empty), .src_pop(src_pop), .snk_data(snk_data),
        .snk_full(snk_full), .snk_push(snk_push), .crc_word(crc_word), .crc_valid(crc_valid)
    );

    function automatic logic [15:0] rword(input int k);
        return 16'(k * 16'h3A71 + 16'h0F1E);
    endfunction
    function automatic logic [15:0] wword(input int k);
        return 16'(k * 16'h5C3B) ^ 16'hC0DE;
    endfunction
    // R12 reference: x^16+x^12+x^5+1, MSB first, seeded per burst.
    function automatic logic [15:0] crc_ref(input int first, input int last, input bit rd);
        logic [15:0] c = 16'h4ABA;
        for (int k = first; k < last; k++) begin
            logic [15:0] d = rd ? rword(k) : wword(k);
            for (int b = 15; b >= 0; b--)
                c = (c[15] ^ d[b]) ? ({c[14:0], 1'b0} ^ 16'h1021) : {c[14:0], 1'b0};
        end
        return c;
    endfunction

    assign src_empty = (src_rd >= src_avail);
    assign src_data  = rword(src_rd);

    // Source FIFO model: advance on every pop.
    always @(posedge clk) if (src_pop) src_rd <= src_rd + 1;

    // Read monitor: one expected word per device strobe change, plus spacing bookkeeping.
    always @(negedge clk) begin
        if (rst_n && dstrobe !== ds_prev) begin
            rtot++;
            if (dd_out !== rword(rx_idx)) begin
                rbad++;
                $display("FAIL R5 word %0d: act=%h exp=%h", rx_idx, dd_out, rword(rx_idx));
            end
            rtot++;
            if (gap < lim_exp) begin
                rbad++;
                $display("FAIL R6 edge gap: act=%0d exp>=%0d", gap, lim_exp);
            end
            if (gap == lim_exp) exact++;
            rx_idx++;
            edges++;
            gap = 1;
        end else if (gap < 63) gap++;
        ds_prev = dstrobe;
    end

    // Write monitor: each push must carry the next host word.
    always @(posedge clk) begin
        if (rst_n && snk_push) begin
            wtot++;
            if (snk_data !== wword(snk_idx)) begin
                wbad++;
                $display("FAIL R9 push %0d: act=%h exp=%h", snk_idx, snk_data, wword(snk_idx));
            end
            snk_idx++;
        end
    end

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        tot++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_mode(input logic [2:0] m);
        mode_val = m; mode_wr = 1'b1; tick(1); mode_wr = 1'b0; tick(1);
    endtask

    task automatic go(input bit rd);
        burst_rd = rd; burst_go = 1'b1; tick(1); burst_go = 1'b0;
    endtask

    task automatic wait_edges(input int n);
        while (edges < n) tick(1);
    endtask

    task automatic release_ack(input string req);
        int hi = 0;
        dmack_n = 1'b1; stop = 1'b0; dev_end = 1'b0;
        repeat (8) begin tick(1); if (crc_valid) hi++; end
        check(hi == 4, req, "crc hold cycles after ack release", hi, 4);
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", tot + rtot + wtot, bad + rbad + wbad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: act=timeout exp=completion");
        finish_run();
    end

    initial begin
        int e, base, ex0, hi, pushes, i, spc;
        tick(3); rst_n = 1'b1; tick(1);

        // R1: reset state and refusal before a mode is written
        check(dmarq == 0, "R1", "dmarq after reset", dmarq, 0);
        check(crc_valid == 0, "R1", "crc_valid after reset", crc_valid, 0);
        check(dd_oe == 0, "R1", "dd_oe after reset", dd_oe, 0);
        check(drdy_n == 1, "R1", "drdy_n after reset", drdy_n, 1);
        go(1'b1); tick(2);
        check(dmarq == 0, "R1", "burst_go with no mode", dmarq, 0);

        // R3: illegal mode value ignored
        set_mode(3'd7); go(1'b1); tick(2);
        check(dmarq == 0, "R3", "burst_go after mode 7", dmarq, 0);

        // R2: deselected device does not drive the request and refuses bursts
        set_mode(3'd0);
        dev_sel = 1'b0; tick(1);
        check(dmarq_oe == 0, "R2", "dmarq_oe while deselected", dmarq_oe, 0);
        go(1'b1); tick(1); dev_sel = 1'b1; tick(2);
        check(dmarq == 0, "R2", "burst_go while deselected", dmarq, 0);
        check(dmarq_oe == 1, "R2", "dmarq_oe when selected", dmarq_oe, 1);

        // R4: acknowledge and stop ignored while idle
        dmack_n = 1'b0; stop = 1'b1; tick(3);
        check(dmarq == 0 && dd_oe == 0, "R4", "request/drive with idle ack", {dmarq, dd_oe}, 0);
        check(crc_valid == 0, "R4", "crc_valid with idle ack", crc_valid, 0);
        check(src_rd == 0, "R4", "source words taken while idle", src_rd, 0);
        dmack_n = 1'b1; stop = 1'b0; tick(2);

        // Mode 0 read burst, host-ended (R5, R6, R7, R8, R10, R12, R13)
        lim_exp = 29; base = rx_idx; ex0 = exact; edges = 0;
        src_avail = src_avail + 3;
        go(1'b1);
        check(dmarq == 1, "R13", "dmarq one cycle after burst_go", dmarq, 1);
        dmack_n = 1'b0; hrdy_n = 1'b0;
        wait_edges(3);
        e = edges; tick(80);
        check(edges == e, "R8", "strobe changes while source empty", edges, e);
        src_avail = src_avail + 3;
        wait_edges(e + 1);
        hrdy_n = 1'b1; e = edges; tick(70);
        check(edges == e, "R7", "strobe changes during host pause", edges, e);
        hrdy_n = 1'b0;
        wait_edges(e + 2);
        check(exact - ex0 == 3, "R6", "mode 0 gaps of exactly 29", exact - ex0, 3);
        tick(2); stop = 1'b1; tick(1);
        check(dmarq == 0, "R10", "dmarq after host stop", dmarq, 0);
        check(crc_valid == 1, "R10", "crc valid after host stop", crc_valid, 1);
        check(crc_word == crc_ref(base, rx_idx, 1'b1), "R12", "read crc mode 0",
              crc_word, crc_ref(base, rx_idx, 1'b1));
        release_ack("R12");

        // Mode 5 read burst, device-ended (R6, R11, R12)
        set_mode(3'd5);
        lim_exp = 5; base = rx_idx; ex0 = exact; edges = 0;
        src_avail = src_avail + 6;
        go(1'b1); dmack_n = 1'b0; hrdy_n = 1'b0;
        wait_edges(6);
        check(exact - ex0 == 5, "R6", "mode 5 gaps of exactly 5", exact - ex0, 5);
        tick(3); dev_end = 1'b1; tick(1);
        check(dmarq == 0, "R11", "dmarq after device end", dmarq, 0);
        check(crc_valid == 0, "R11", "crc before host stop", crc_valid, 0);
        tick(4);
        check(crc_valid == 0, "R11", "crc still waiting for stop", crc_valid, 0);
        stop = 1'b1; tick(1);
        check(crc_valid == 1, "R11", "crc after host stop", crc_valid, 1);
        check(crc_word == crc_ref(base, rx_idx, 1'b1), "R12", "read crc mode 5",
              crc_word, crc_ref(base, rx_idx, 1'b1));
        release_ack("R12");
        hrdy_n = 1'b1;
        check(short_gaps == 0 && rx_idx == src_avail, "R5", "all offered words delivered", rx_idx, src_avail);

        // Mode 3 write burst with a sink-full pause, device-ended (R8, R9, R12)
        set_mode(3'd3);
        base = snk_idx; i = 0; spc = 0;
        go(1'b0); dmack_n = 1'b0; tick(1);
        while (i < 8) begin
            if (i == 4) begin
                snk_full = 1'b1;
                pushes = snk_idx; hi = 0;
                repeat (10) begin tick(1); if (drdy_n) hi++; end
                check(hi == 10, "R8", "drdy_n high while sink full", hi, 10);
                check(snk_idx == pushes, "R8", "pushes while sink full", snk_idx, pushes);
                snk_full = 1'b0;
                i++;
                dd_in = wword(base + 4); hstrobe = ~hstrobe; tick(1);
            end else if (!drdy_n && spc >= 2) begin
                dd_in = wword(base + i); hstrobe = ~hstrobe; i++; spc = 0; tick(1);
            end else begin
                spc++; tick(1);
            end
        end
        tick(3);
        check(snk_idx - base == 8, "R9", "words pushed in write burst", snk_idx - base, 8);
        dev_end = 1'b1; tick(1);
        check(dmarq == 0 && drdy_n == 1, "R11", "write device end", {dmarq, drdy_n}, 2'b01);
        stop = 1'b1; tick(1);
        check(crc_word == crc_ref(base, snk_idx, 1'b0), "R12", "write crc",
              crc_word, crc_ref(base, snk_idx, 1'b0));
        release_ack("R12");

        finish_run();
    end

endmodule